// File: doc/BRIEF.md
# Narrow-to-wide DMA bus bridge

The bridge lets a 32-bit DMA master, which uses the classic Wishbone handshake, reach a 64-bit pipelined Wishbone port on the main bus arbiter. In the classic handshake the master holds its strobe until it sees acknowledge. On the wide side the request is presented as a pipelined strobe, which the target either accepts or stalls. The acknowledge comes back later, while the cycle signal stays high.

The bridge captures each upstream request in a register and issues it on the wide side. Word-address bit 0 on the narrow side, which is byte-address bit 2, chooses the 32-bit lane. The byte selects go to that lane and the write data is copied onto both lanes. When the wide acknowledge arrives, it is registered together with the chosen half of the read data and returned upstream as a one-cycle acknowledge. Against a direct connection this costs exactly two cycles. Only one transfer is in flight at any time. Back-pressure is carried by the downstream stall: while stall is high, the strobe and every request field stay unchanged. Upstream, back-pressure is simply the delay before acknowledge.

A master that leaves its strobe high after an acknowledge does not start a second transfer. It must first drop the strobe for at least one cycle. The master must hold cycle, strobe and the request fields until acknowledge. The wide target must not acknowledge in the same cycle that it accepts a strobe.

Top module: `dma_bus_bridge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, dn_cyc, dn_stb and up_ack are 0 and up_dat_r is 0.
- R2: Suppose a rising clock edge samples up_cyc=1 and up_stb=1 while the bridge is idle. From the next cycle, dn_cyc and dn_stb are 1, with dn_adr = up_adr[AW-1:1] and dn_we = up_we.
- R3: While dn_stb=1 and dn_stall=1, dn_stb and all request fields stay unchanged. In the cycle after an edge samples dn_stb=1 with dn_stall=0, dn_stb is 0. dn_cyc stays 1 until an edge samples dn_ack=1, and is 0 from the next cycle.
- R4: dn_sel[3:0]=up_sel and dn_sel[7:4]=0 when up_adr[0]=0. dn_sel[7:4]=up_sel and dn_sel[3:0]=0 when up_adr[0]=1.
- R5: dn_dat_w = {up_dat_w, up_dat_w}.
- R6: On acknowledge, up_dat_r takes dn_dat_r[31:0] for lane 0, or dn_dat_r[63:32] for lane 1, from the captured up_adr[0]. It holds that value until the next acknowledge.
- R7: up_ack is 1 for exactly the one cycle after an edge that samples dn_ack=1 while a request has been accepted and not yet acknowledged.
- R8: With S stall cycles, and an acknowledge G cycles after the cycle following acceptance, up_ack is seen 3+S+G cycles after the master raises its strobe. That is two cycles more than a direct connection.
- R9: After an acknowledge, no new wide request is issued while up_stb stays 1. Once up_stb has been sampled 0, a new request is taken.
- R10: A dn_ack that arrives while no transfer is outstanding produces no up_ack and leaves up_dat_r unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_cyc | input | 1 | Narrow side bus cycle |
| up_stb | input | 1 | Narrow side strobe, held until acknowledge |
| up_we | input | 1 | Narrow side write enable |
| up_adr | input | AW (30) | Narrow side 32-bit word address |
| up_sel | input | 4 | Narrow side byte selects |
| up_dat_w | input | 32 | Narrow side write data |
| up_dat_r | output | 32 | Narrow side read data, registered |
| up_ack | output | 1 | Narrow side acknowledge, one-cycle pulse |
| dn_cyc | output | 1 | Wide side bus cycle |
| dn_stb | output | 1 | Wide side pipelined strobe |
| dn_we | output | 1 | Wide side write enable |
| dn_adr | output | AW-1 (29) | Wide side 64-bit word address |
| dn_sel | output | 8 | Wide side byte selects |
| dn_dat_w | output | 64 | Wide side write data |
| dn_dat_r | input | 64 | Wide side read data |
| dn_stall | input | 1 | Wide side stall |
| dn_ack | input | 1 | Wide side acknowledge |

## Verification
Writes and reads are sent to both lanes with sparse and full byte selects. A lane-steering error and a copy-versus-zero error on the write data therefore show up both in the wide request and in the target memory. Transfers run with zero and with several stall cycles, and with zero and with delayed acknowledges. This separates a strobe that is dropped or repeated under stall from one that is correct, and confirms that latency grows one-for-one with each stall or wait cycle. A master that keeps its strobe high after acknowledge checks for unwanted re-issue. Stray acknowledges while idle, together with random data on the read bus outside acknowledge cycles, expose any capture that is not qualified by acknowledge.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/dbb_lane_pack.sv
module dbb_lane_pack #(
  parameter int UP_DW = 32,
  localparam int UP_SW = UP_DW / 8,
  localparam int DN_DW = 2 * UP_DW,
  localparam int DN_SW = 2 * UP_SW
) (
  input  logic             lane,
  input  logic [UP_SW-1:0] up_sel,
  input  logic [UP_DW-1:0] up_dat,
  output logic [DN_SW-1:0] wide_sel,
  output logic [DN_DW-1:0] wide_dat
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign wide_sel[g*UP_SW +: UP_SW] = (lane == 1'(g)) ? up_sel : '0;
    assign wide_dat[g*UP_DW +: UP_DW] = up_dat;
  end
endmodule

// File: rtl/dbb_req_stage.sv
module dbb_req_stage
  import dbb_pkg::*;
#(
  parameter int AW    = 30,
  parameter int UP_DW = 32,
  localparam int DN_DW = 2 * UP_DW,
  localparam int DN_SW = DN_DW / 8,
  localparam int DN_AW = AW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_cyc,
  input  logic             up_stb,
  input  logic             up_we,
  input  logic [AW-1:0]    up_adr,
  input  logic [DN_SW-1:0] wide_sel,
  input  logic [DN_DW-1:0] wide_dat,
  input  logic             dn_stall,
  input  logic             dn_ack,
  output logic             dn_cyc,
  output logic             dn_stb,
  output logic             dn_we,
  output logic [DN_AW-1:0] dn_adr,
  output logic [DN_SW-1:0] dn_sel,
  output logic [DN_DW-1:0] dn_dat_w,
  output logic             lane_q,
  output logic             take
);
  xfer_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dn_we    <= 1'b0;
      dn_adr   <= '0;
      dn_sel   <= '0;
      dn_dat_w <= '0;
      lane_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (up_cyc && up_stb) begin
          state_q  <= ST_ISSUE;
          dn_we    <= up_we;
          dn_adr   <= up_adr[AW-1:1];
          dn_sel   <= wide_sel;
          dn_dat_w <= wide_dat;
          lane_q   <= up_adr[0];
        end
        ST_ISSUE: if (!dn_stall) state_q <= ST_WAIT;
        ST_WAIT:  if (dn_ack)    state_q <= ST_HOLD;
        ST_HOLD:  if (!up_stb)   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_stb = (state_q == ST_ISSUE);
  assign dn_cyc = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign take   = (state_q == ST_WAIT) && dn_ack;

  a_r3_stb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stb && dn_stall) |=> (dn_stb && $stable(dn_adr) && $stable(dn_sel) && $stable(dn_dat_w)));
  a_r3_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_stb && !dn_stall) |=> !dn_stb);
  a_r3_cyc_covers_stb: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stb |-> dn_cyc);
  a_r4_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stb |-> ((dn_sel[DN_SW-1:DN_SW/2] == '0) || (dn_sel[DN_SW/2-1:0] == '0)));
  a_r9_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (take && up_stb) |=> !dn_stb);
endmodule

// File: rtl/dbb_resp_stage.sv
module dbb_resp_stage #(
  parameter int UP_DW = 32,
  localparam int DN_DW = 2 * UP_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             lane_q,
  input  logic [DN_DW-1:0] dn_dat_r,
  output logic             up_ack,
  output logic [UP_DW-1:0] up_dat_r
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_ack   <= 1'b0;
      up_dat_r <= '0;
    end else begin
      up_ack <= take;
      if (take) up_dat_r <= lane_q ? dn_dat_r[DN_DW-1:UP_DW] : dn_dat_r[UP_DW-1:0];
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |=> !up_ack);
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(up_dat_r));
endmodule

// File: rtl/dma_bus_bridge.sv
module dma_bus_bridge #(
  parameter int AW    = 30,
  parameter int UP_DW = 32,
  localparam int UP_SW = UP_DW / 8,
  localparam int DN_DW = 2 * UP_DW,
  localparam int DN_SW = 2 * UP_SW,
  localparam int DN_AW = AW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_cyc,
  input  logic             up_stb,
  input  logic             up_we,
  input  logic [AW-1:0]    up_adr,
  input  logic [UP_SW-1:0] up_sel,
  input  logic [UP_DW-1:0] up_dat_w,
  output logic [UP_DW-1:0] up_dat_r,
  output logic             up_ack,
  output logic             dn_cyc,
  output logic             dn_stb,
  output logic             dn_we,
  output logic [DN_AW-1:0] dn_adr,
  output logic [DN_SW-1:0] dn_sel,
  output logic [DN_DW-1:0] dn_dat_w,
  input  logic [DN_DW-1:0] dn_dat_r,
  input  logic             dn_stall,
  input  logic             dn_ack
);
  logic [DN_SW-1:0] wide_sel;
  logic [DN_DW-1:0] wide_dat;
  logic             lane_q;
  logic             take;

  dbb_lane_pack #(.UP_DW(UP_DW)) u_pack (
    .lane(up_adr[0]), .up_sel(up_sel), .up_dat(up_dat_w),
    .wide_sel(wide_sel), .wide_dat(wide_dat)
  );

  dbb_req_stage #(.AW(AW), .UP_DW(UP_DW)) u_req (
    .clk(clk), .rst_n(rst_n), .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we),
    .up_adr(up_adr), .wide_sel(wide_sel), .wide_dat(wide_dat),
    .dn_stall(dn_stall), .dn_ack(dn_ack), .dn_cyc(dn_cyc), .dn_stb(dn_stb),
    .dn_we(dn_we), .dn_adr(dn_adr), .dn_sel(dn_sel), .dn_dat_w(dn_dat_w),
    .lane_q(lane_q), .take(take)
  );

  dbb_resp_stage #(.UP_DW(UP_DW)) u_resp (
    .clk(clk), .rst_n(rst_n), .take(take), .lane_q(lane_q),
    .dn_dat_r(dn_dat_r), .up_ack(up_ack), .up_dat_r(up_dat_r)
  );

  a_r10_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_ack && !dn_cyc) |=> !up_ack);
endmodule

// File: tb/dma_bus_bridge_bench.sv
module dma_bus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_cyc = 1'b0, up_stb = 1'b0, up_we = 1'b0;
  logic [29:0] up_adr = '0;
  logic [3:0]  up_sel = '0;
  logic [31:0] up_dat_w = '0;
  logic [31:0] up_dat_r;
  logic        up_ack;
  logic        dn_cyc, dn_stb, dn_we;
  logic [28:0] dn_adr;
  logic [7:0]  dn_sel;
  logic [63:0] dn_dat_w;
  logic [63:0] dn_dat_r = '0;
  logic        dn_stall = 1'b0, dn_ack = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  dma_bus_bridge u_dma_bus_bridge (
    .clk(clk), .rst_n(rst_n), .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we),
    .up_adr(up_adr), .up_sel(up_sel), .up_dat_w(up_dat_w), .up_dat_r(up_dat_r),
    .up_ack(up_ack), .dn_cyc(dn_cyc), .dn_stb(dn_stb), .dn_we(dn_we),
    .dn_adr(dn_adr), .dn_sel(dn_sel), .dn_dat_w(dn_dat_w), .dn_dat_r(dn_dat_r),
    .dn_stall(dn_stall), .dn_ack(dn_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model, updated on each rising edge ----------------
  int          m_phase = 0;  // 0 free, 1 request shown, 2 waiting for reply, 3 waiting for strobe low
  logic        e_ack = 1'b0;
  logic [31:0] e_rd = '0;
  logic        e_lane = 1'b0, e_we = 1'b0;
  logic [28:0] e_adr = '0;
  logic [7:0]  e_sel = '0;
  logic [63:0] e_dat = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; e_ack = 1'b0; e_rd = '0;
    end else begin
      e_ack = 1'b0;
      if (m_phase == 0) begin
        if (up_cyc && up_stb) begin
          m_phase = 1;
          e_lane = up_adr[0];
          e_adr = up_adr[29:1];
          e_we = up_we;
          e_sel = up_adr[0] ? {up_sel, 4'h0} : {4'h0, up_sel};
          e_dat = {up_dat_w, up_dat_w};
        end
      end else if (m_phase == 1) begin
        if (!dn_stall) m_phase = 2;
      end else if (m_phase == 2) begin
        if (dn_ack) begin
          m_phase = 3;
          e_ack = 1'b1;
          e_rd = e_lane ? dn_dat_r[63:32] : dn_dat_r[31:0];
        end
      end else begin
        if (!up_stb) m_phase = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(dn_stb == (m_phase == 1), "R3 dn_stb", 64'(dn_stb), 64'(m_phase == 1));
      chk(dn_cyc == (m_phase == 1 || m_phase == 2), "R3 dn_cyc", 64'(dn_cyc), 64'(m_phase == 1 || m_phase == 2));
      chk(up_ack == e_ack, "R7 up_ack", 64'(up_ack), 64'(e_ack));
      chk(up_dat_r == e_rd, "R6 up_dat_r", 64'(up_dat_r), 64'(e_rd));
      if (m_phase == 1) begin
        chk(dn_adr == e_adr, "R2 dn_adr", 64'(dn_adr), 64'(e_adr));
        chk(dn_we == e_we, "R2 dn_we", 64'(dn_we), 64'(e_we));
        chk(dn_sel == e_sel, "R4 dn_sel", 64'(dn_sel), 64'(e_sel));
        chk(dn_dat_w == e_dat, "R5 dn_dat_w", dn_dat_w, e_dat);
      end
    end
  end

  // ---------------- wide-side target ----------------
  logic [63:0] slv_mem [16];
  logic [63:0] shadow  [16];
  logic [63:0] rsp_word = '0;
  int stall_left = 0;
  int ack_gap = 0;
  int pending = 0;
  bit stray = 1'b0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      slv_mem[i] = {32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000, ~(32'(i) * 32'h1111_0000)};
      shadow[i]  = slv_mem[i];
    end
    forever begin
      @(negedge clk);
      dn_ack = 1'b0;
      dn_dat_r = {$urandom, $urandom};
      if (pending > 0) begin
        pending--;
        if (pending == 0) begin dn_ack = 1'b1; dn_dat_r = rsp_word; end
      end else if (stray) begin
        dn_ack = 1'b1;
        stray = 1'b0;
      end
      if (dn_stb) begin
        if (stall_left > 0) begin
          dn_stall = 1'b1;
          stall_left--;
        end else begin
          dn_stall = 1'b0;
          if (dn_we) begin
            for (int b = 0; b < 8; b++)
              if (dn_sel[b]) slv_mem[dn_adr[3:0]][b*8 +: 8] = dn_dat_w[b*8 +: 8];
            rsp_word = {$urandom, $urandom};
          end else begin
            rsp_word = slv_mem[dn_adr[3:0]];
          end
          pending = ack_gap + 1;
        end
      end else begin
        dn_stall = 1'($urandom);
      end
    end
  end

  // ---------------- narrow-side master ----------------
  task automatic xfer(input bit we, input logic [29:0] adr, input logic [3:0] sel,
                      input logic [31:0] dat, input int stall, input int gap, input int hold);
    int lat;
    logic [31:0] exp_rd;
    @(negedge clk);
    stall_left = stall;
    ack_gap = gap;
    up_cyc = 1'b1; up_stb = 1'b1; up_we = we; up_adr = adr; up_sel = sel; up_dat_w = dat;
    exp_rd = adr[0] ? shadow[adr[4:1]][63:32] : shadow[adr[4:1]][31:0];
    if (we)
      for (int b = 0; b < 4; b++)
        if (sel[b]) shadow[adr[4:1]][32*adr[0] + b*8 +: 8] = dat[b*8 +: 8];
    lat = 0;
    do begin @(negedge clk); lat++; end while (!up_ack && lat < 50);
    chk(lat == 3 + stall + gap, "R8 latency", 64'(lat), 64'(3 + stall + gap));
    if (!we) chk(up_dat_r == exp_rd, "R6 read lane", 64'(up_dat_r), 64'(exp_rd));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(dn_stb == 1'b0 && dn_cyc == 1'b0, "R9 no reissue while strobe held", 64'({dn_cyc, dn_stb}), 64'(0));
    end
    @(negedge clk);
    up_stb = 1'b0; up_cyc = 1'b0;
    up_dat_w = $urandom; up_sel = 4'($urandom); up_adr = 30'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({dn_cyc, dn_stb, up_ack} == 3'b000, "R1 reset outputs", 64'({dn_cyc, dn_stb, up_ack}), 64'(0));
    chk(up_dat_r == '0, "R1 reset read data", 64'(up_dat_r), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({dn_cyc, dn_stb, up_ack} == 3'b000, "R1 after reset", 64'({dn_cyc, dn_stb, up_ack}), 64'(0));

    // R8 baseline: no stall, immediate reply
    xfer(1'b1, 30'h2, 4'hF, 32'h1234_5678, 0, 0, 0);
    xfer(1'b0, 30'h2, 4'hF, 32'h0, 0, 0, 0);
    // R4/R5 lane 1 with sparse selects, stalls and waits
    xfer(1'b1, 30'h3, 4'b1010, 32'hCAFE_BEEF, 2, 0, 0);
    xfer(1'b0, 30'h3, 4'hF, 32'h0, 0, 3, 0);
    xfer(1'b1, 30'h4, 4'b0001, 32'h0000_00AA, 1, 2, 0);
    xfer(1'b0, 30'h4, 4'hF, 32'h0, 3, 1, 0);
    xfer(1'b0, 30'h5, 4'hF, 32'h0, 0, 0, 0);

    // R9: strobe left high after acknowledge, then a new request after a drop
    xfer(1'b0, 30'h9, 4'hF, 32'h0, 1, 1, 6);
    xfer(1'b1, 30'h9, 4'hC, 32'h5555_AAAA, 0, 0, 0);

    // R10: stray acknowledge while idle
    repeat (2) @(negedge clk);
    stray = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(up_ack == 1'b0, "R10 stray ack ignored", 64'(up_ack), 64'(0));
    end
    xfer(1'b0, 30'h9, 4'hF, 32'h0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 300; n++)
      xfer(1'($urandom), 30'($urandom % 32), 4'($urandom), $urandom,
           int'($urandom % 4), int'($urandom % 3), int'($urandom % 3));

    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++)
      chk(slv_mem[i] == shadow[i], "R5 target memory contents", slv_mem[i], shadow[i]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'(1), 64'(0));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule